// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block is a free-running processor cycle counter steered by a small monitor control register. Both registers sit behind one single-cycle request port. Each request carries a read/write flag, a register select, write data and the privilege level of the requester. A separate user-enable input decides whether unprivileged code may touch the control register. The counter register is always closed to unprivileged code.

Once enabled, the counter advances on every core clock. With the divider selected, it instead advances once per 64 clocks, driven by an internal 6-bit prescaler. A prohibit bit forces it to hold regardless of the enable. Software can read the count, load it directly, or clear it through a self-clearing bit in the control register. The prescaler phase restarts whenever the count is cleared or loaded, or the divider setting changes. As a result, the first divided count always lands a full 64 clocks later.

Each request is answered exactly one cycle later with a valid strobe, read data and an error flag.

Top module: `cycle_counter_unit`

## Requirements
- R1: After a synchronous reset the control register and the count both read 0, and the count does not advance.
- R2: A permitted control write stores only bit 0 (enable), bit 3 (divider), bit 4 and bit 5 (prohibit), which is mask 0x39. Every other control bit reads back as 0.
- R3: A permitted control write with bit 2 set clears the count to 0, taking priority over that cycle's increment. Bit 2 is never stored and always reads 0.
- R4: The count advances only while the enable bit is 1 and the prohibit bit is 0. Otherwise it holds.
- R5: With the divider bit set, the count advances once per 64 clocks. The first count after a clear, a load or a divider change comes 64 clocks after that write.
- R6: A permitted counter write loads the written value exactly, whether or not counting is active. The write takes priority over that cycle's increment, and counting continues from the loaded value.
- R7: The count wraps from 0xFFFFFFFF to 0 with no other side effect.
- R8: A control access at privilege level 0 with user_en low returns rsp_err=1 and rsp_rdata=0, and changes nothing.
- R9: A counter access at privilege level 0 returns rsp_err=1 and rsp_rdata=0, and changes nothing.
- R10: Every request is answered on the next cycle with rsp_valid=1. A permitted read returns the register value from before the request's clock edge. A write returns rsp_rdata=0 and rsp_err=0. In req_sel, 0 selects the control register and 1 selects the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control register, 1 = counter |
| req_wdata | input | 32 | Write data |
| priv_level | input | 2 | Requester privilege, 0 = unprivileged |
| user_en | input | 1 | Allows level-0 control access when 1 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| rsp_err | output | 1 | Access refused (undefined-instruction flag) |

## Verification
A corrupted prescaler phase shows up as the first divided count arriving earlier or later than 64 clocks after the divider write. Reading the count at clocks 64 and 65 after that write exposes the error within one read. A stray control bit, or a latched clear bit, appears on the very next control read. A wrong priority between load, clear and increment shifts the value returned by the read placed immediately after the write by exactly one. A refused access that leaks into state is revealed by the next permitted read of the same register.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 2;
  localparam int CTRL_DIV_BIT = 3;
  localparam int CTRL_PRH_BIT = 5;
  localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_0039;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cc_access_gate.sv
module cc_access_gate #(
  parameter int PRIV_W = 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [PRIV_W-1:0] priv_level,
  input  logic              user_en,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output logic              rd_ok,
  output logic              deny
);
  import cc_pkg::*;

  logic is_user;
  logic ctrl_ok;
  logic cnt_ok;
  logic allowed;

  always_comb begin
    is_user = (priv_level == '0);
    ctrl_ok = !is_user || user_en;
    cnt_ok  = !is_user;
    allowed = (req_sel == SEL_CTRL) ? ctrl_ok : cnt_ok;
    deny    = req_valid && !allowed;
    ctrl_wr = req_valid && req_write && (req_sel == SEL_CTRL) && ctrl_ok;
    cnt_wr  = req_valid && req_write && (req_sel == SEL_CNT) && cnt_ok;
    rd_ok   = req_valid && !req_write && allowed;
  end
endmodule

// File: rtl/cc_ctrl_reg.sv
module cc_ctrl_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              clr_pulse,
  output logic              div_change,
  output logic              count_active,
  output logic              div_sel
);
  import cc_pkg::*;

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q <= (ctrl_q & ~KEEP) | (wdata & KEEP);
    end
  end

  always_comb begin
    clr_pulse    = wr && wdata[CTRL_CLR_BIT];
    div_change   = wr && (wdata[CTRL_DIV_BIT] != ctrl_q[CTRL_DIV_BIT]);
    count_active = ctrl_q[CTRL_EN_BIT] && !ctrl_q[CTRL_PRH_BIT];
    div_sel      = ctrl_q[CTRL_DIV_BIT];
  end
endmodule

// File: rtl/cc_prescaler.sv
module cc_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             div_sel,
  input  logic             restart,
  output logic [PRE_W-1:0] pre_q,
  output logic             tick
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (active && div_sel) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = active && (!div_sel || (&pre_q));
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/cycle_counter_unit.sv
module cycle_counter_unit #(
  parameter int DATA_W = 32,
  parameter int PRIV_W = 2,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PRIV_W-1:0] priv_level,
  input  logic              user_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  import cc_pkg::*;

  logic              ctrl_wr;
  logic              cnt_wr;
  logic              rd_ok;
  logic              deny;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] count_q;
  logic [PRE_W-1:0]  pre_q;
  logic              clr_pulse;
  logic              div_change;
  logic              count_active;
  logic              div_sel;
  logic              tick;
  logic              pre_restart;
  logic [DATA_W-1:0] rd_mux;

  cc_access_gate #(.PRIV_W(PRIV_W)) u_gate (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .priv_level(priv_level),
    .user_en   (user_en),
    .ctrl_wr   (ctrl_wr),
    .cnt_wr    (cnt_wr),
    .rd_ok     (rd_ok),
    .deny      (deny)
  );

  cc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr          (ctrl_wr),
    .wdata       (req_wdata),
    .ctrl_q      (ctrl_q),
    .clr_pulse   (clr_pulse),
    .div_change  (div_change),
    .count_active(count_active),
    .div_sel     (div_sel)
  );

  assign pre_restart = clr_pulse || cnt_wr || div_change;

  cc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (count_active),
    .div_sel(div_sel),
    .restart(pre_restart),
    .pre_q  (pre_q),
    .tick   (tick)
  );

  cc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_pulse),
    .load    (cnt_wr),
    .load_val(req_wdata),
    .tick    (tick),
    .count_q (count_q)
  );

  assign rd_mux = (req_sel == SEL_CTRL) ? ctrl_q : count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= deny;
      rsp_rdata <= rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cycle_counter_checker.sv
module cycle_counter_checker #(
  parameter int DATA_W = 32,
  parameter int PRIV_W = 2,
  parameter int PRE_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_sel,
  input logic [PRIV_W-1:0] priv_level,
  input logic              user_en,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] count_q,
  input logic [PRE_W-1:0]  pre_q
);
  import cc_pkg::*;

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP_MASK);

  logic any_wr;
  logic run;
  assign any_wr = req_valid && req_write;
  assign run    = ctrl_q[CTRL_EN_BIT] && !ctrl_q[CTRL_PRH_BIT];

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~KEEP) == '0);

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !any_wr) |=> $stable(count_q));

  // R4
  step_when_on_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ctrl_q[CTRL_DIV_BIT] && !any_wr) |=> count_q == DATA_W'($past(count_q) + 1'b1));

  // R5
  div_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && ctrl_q[CTRL_DIV_BIT] && !(&pre_q) && !any_wr) |=> $stable(count_q));

  // R8
  ctrl_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == SEL_CTRL && priv_level == '0 && !user_en)
      |=> (rsp_err && rsp_rdata == '0 && $stable(ctrl_q)));

  // R9
  cnt_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == SEL_CNT && priv_level == '0) |=> (rsp_err && rsp_rdata == '0));

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
endmodule

bind cycle_counter_unit cycle_counter_checker #(
  .DATA_W(DATA_W), .PRIV_W(PRIV_W), .PRE_W(PRE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sel   (req_sel),
  .priv_level(priv_level),
  .user_en   (user_en),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .ctrl_q    (ctrl_q),
  .count_q   (count_q),
  .pre_q     (pre_q)
);

// File: tb/tb_cycle_counter_unit.sv
module tb_cycle_counter_unit;
  localparam int W = 32;
  localparam int NVEC = 15;
  // {wr, sel, priv[1:0], uen, wdata[31:0], exp_err, exp_rdata[31:0]} = 70 bits
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_0000}, // R1 ctrl reads 0
    {1'b1, 1'b0, 2'd1, 1'b0, 32'hFFFF_FFFF,1'b0, 32'h0000_0000}, // R2/R3 write all ones
    {1'b0, 1'b0, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_0039}, // R2 mask 0x39, bit2 reads 0
    {1'b1, 1'b1, 2'd1, 1'b0, 32'h0000_1234,1'b0, 32'h0000_0000}, // R6 load while prohibited
    {1'b0, 1'b1, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_1234}, // R4/R6 held at loaded value
    {1'b1, 1'b0, 2'd0, 1'b0, 32'h0,        1'b1, 32'h0000_0000}, // R8 ctrl write refused
    {1'b0, 1'b0, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_0039}, // R8 no effect
    {1'b0, 1'b1, 2'd0, 1'b1, 32'h0,        1'b1, 32'h0000_0000}, // R9 counter read refused
    {1'b1, 1'b1, 2'd0, 1'b1, 32'h0000_DEAD,1'b1, 32'h0000_0000}, // R9 counter write refused
    {1'b0, 1'b1, 2'd2, 1'b0, 32'h0,        1'b0, 32'h0000_1234}, // R9 no effect
    {1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0020,1'b0, 32'h0000_0000}, // R8 user_en grants access
    {1'b0, 1'b0, 2'd0, 1'b1, 32'h0,        1'b0, 32'h0000_0020}, // R8 stored
    {1'b0, 1'b1, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_1234}, // R4 prohibit holds
    {1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0024,1'b0, 32'h0000_0000}, // R3 clear
    {1'b0, 1'b1, 2'd1, 1'b0, 32'h0,        1'b0, 32'h0000_0000}  // R3 count now 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic req_sel = 1'b0;
  logic [W-1:0] req_wdata = '0;
  logic [1:0] priv_level = 2'd1;
  logic user_en = 1'b0;
  logic rsp_valid;
  logic [W-1:0] rsp_rdata;
  logic rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] got, first;
  logic gerr;

  always #2 clk = ~clk;

  cycle_counter_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .priv_level(priv_level),
    .user_en(user_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the response.
  task automatic xfer(input logic wr, input logic sel, input logic [1:0] pl, input logic ue,
                      input logic [W-1:0] d, output logic err, output logic [W-1:0] rd);
    req_valid = 1'b1; req_write = wr; req_sel = sel; priv_level = pl; user_en = ue; req_wdata = d;
    @(negedge clk);
    if (rsp_valid !== 1'b1) begin
      errors++; checks++;
      $display("FAIL R10: actual rsp_valid %b expected 1", rsp_valid);
    end
    err = rsp_err; rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    idle(5);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R1 count stays 0 after reset", got, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][69], VEC[i][68], VEC[i][67:66], VEC[i][65], VEC[i][64:33], gerr, got);
      check($sformatf("vec%0d err (R8/R9/R10)", i), {31'b0, gerr}, {31'b0, VEC[i][32]});
      check($sformatf("vec%0d rdata (R2/R3/R6)", i), got, VEC[i][31:0]);
    end

    // R4/R6: count every cycle from loaded value
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h0, gerr, got);
    xfer(1'b1, 1'b1, 2'd1, 1'b0, 32'd100, gerr, got);
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h1, gerr, got);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, first);
    check("R6 count resumes from load", first, 32'd100);
    idle(9);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R4 advances one per clock", got, 32'd110);

    // R6: write while counting beats that cycle's increment
    xfer(1'b1, 1'b1, 2'd1, 1'b0, 32'd500, gerr, got);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R6 load while enabled exact", got, 32'd500);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R6 continues after load", got, 32'd501);

    // R3: clear while counting beats increment
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h5, gerr, got);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R3 clear beats increment", got, 32'd0);
    xfer(1'b0, 1'b0, 2'd1, 1'b0, '0, gerr, got);
    check("R3 clear bit not stored", got, 32'h1);

    // R4: prohibit with enable set holds
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h21, gerr, got);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, first);
    idle(20);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R4 prohibit holds", got, first);

    // R7: wrap
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h0, gerr, got);
    xfer(1'b1, 1'b1, 2'd1, 1'b0, 32'hFFFF_FFFE, gerr, got);
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h1, gerr, got);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R7 before wrap", got, 32'hFFFF_FFFE);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R7 at max", got, 32'hFFFF_FFFF);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R7 wrapped to 0", got, 32'h0);

    // R5: divider, first count 64 clocks after the divider write
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h4, gerr, got);
    xfer(1'b1, 1'b0, 2'd1, 1'b0, 32'h9, gerr, got);
    idle(63);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R5 no count before 64 clocks", got, 32'd0);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R5 one count at 64 clocks", got, 32'd1);
    // R5: load restarts the phase
    idle(10);
    xfer(1'b1, 1'b1, 2'd1, 1'b0, 32'd7, gerr, got);
    idle(63);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R5 load restarts prescaler", got, 32'd7);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R5 count 64 clocks after load", got, 32'd8);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(4);
    xfer(1'b0, 1'b0, 2'd1, 1'b0, '0, gerr, got);
    check("R1 ctrl 0 after reset", got, 32'h0);
    xfer(1'b0, 1'b1, 2'd1, 1'b0, '0, gerr, got);
    check("R1 count 0 after reset", got, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule